// File: doc/BRIEF.md
# I2S Audio Serial Receiver

This block turns the serial data line of an I2S link into parallel sample words. Each completed word goes to an external sample buffer as one write. In master mode the block makes the bit clock and word select itself from the system clock through a programmable divider. In slave mode it samples a bit clock and word select that another device drives, after passing both through a synchronizer.

Bits are sampled on the rising bit clock, most significant bit first. A word ends on the bit during which word select has already changed, as I2S framing requires. The finished word is written with its received bits in the low positions and zeros above them. The write address carries the channel in its lowest bit: left words go to even addresses and right words to odd ones, and a swap input reverses this. The upper address bits count stereo frames. Resolution, divider, swap, mode and enable are all runtime inputs. They are meant to be changed only while the block is disabled.

Top module: `aud_i2s_rx`

## Requirements
- R1: The effective resolution is `cfg_res` when `cfg_res` is between 8 and DATA_W. Any other value makes the effective resolution 8.
- R2: Serial bits are sampled on the rising bit clock and shifted in MSB first. They fill the low bits of `wr_data`, and every bit at or above the effective resolution is 0.
- R3: In master mode, `sck_out` has a period of 2*(`cfg_div`+2) system clocks. While the block is disabled or in slave mode, `sck_out` stays 0.
- R4: In master mode, `ws_out` toggles only together with a falling edge of `sck_out`, once every effective-resolution bit clocks. A value of 1 means the right channel and 0 the left channel.
- R5: A word ends at the rising bit clock where the sampled word select differs from the previous sample. That bit is the word's last bit, and the word belongs to the channel of the previous sample. The next bit starts the new word.
- R6: `wr_addr[0]` equals the word's channel XOR `cfg_swap`, so with swap 0 left words go to even addresses and right words to odd ones. `wr_addr[ADDR_W-1:1]` is a frame count. It starts at 0 on enable and increments after each right word.
- R7: Each written word has a write strobe of exactly one cycle. The strobe is never high in two consecutive cycles.
- R8: A word with fewer bits than the effective resolution is written low-aligned. Bits beyond the effective resolution are dropped, so the first received bits are kept.
- R9: The first word boundary after enable only aligns the receiver and produces no write.
- R10: While `cfg_en` is 0, the shift register, bit count and frame count are cleared and no write strobe is produced. After reset, all outputs are 0.
- R11: In slave mode, the block uses `sck_in` and `ws_in`, both synchronized through two flops before edge detection. `sd_in` goes through the same delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Receiver enable |
| cfg_master | input | 1 | 1: generate bit clock and word select; 0: take them from the pins |
| cfg_swap | input | 1 | Reverses the channel-to-address-parity mapping |
| cfg_res | input | 5 | Requested bits per word |
| cfg_div | input | DIV_W | Bit clock divider value |
| sck_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sd_in | input | 1 | Serial data |
| sck_out | output | 1 | Generated bit clock (master mode) |
| ws_out | output | 1 | Generated word select (master mode) |
| wr_stb | output | 1 | One-cycle write strobe to the sample buffer |
| wr_data | output | DATA_W | Received sample word |
| wr_addr | output | ADDR_W | Buffer address: frame count and channel parity |

## Verification
Four behaviours are checked on every cycle:
- the write strobe is always a single cycle;
- no written word has bits set above the effective resolution;
- no strobe appears while the block is disabled;
- in master mode, the generated word select changes only on a falling bit clock, and both generated lines stay low when they are not in use.

Only the bench scenarios can show the rest:
- that word contents match what was sent, including the truncated and short words;
- the resolution clamping;
- the parity and frame count of the addresses under both swap settings;
- the bit clock period for a given divider;
- that the alignment word after enable is suppressed.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
    localparam int RES_MIN = 8;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // One sampling opportunity on the serial line
    typedef struct packed {
        logic  rise;
        logic  sd;
        chan_e ws;
    } bit_evt_t;

    // Requested resolution bounded to [RES_MIN, max_bits], otherwise RES_MIN
    function automatic logic [5:0] clamp_res(input logic [4:0] req, input int unsigned max_bits);
        if (req < 5'(RES_MIN) || 32'(req) > max_bits)
            return 6'(RES_MIN);
        return {1'b0, req};
    endfunction
endpackage

// File: rtl/aud_rx_bitgen.sv
module aud_rx_bitgen #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] res,
    output logic             sck,
    output logic             ws,
    output logic             rise_p
);
    localparam int HC_W = DIV_W + 1;

    logic [HC_W-1:0]  half_cnt;
    logic [CNT_W-1:0] fall_cnt;
    logic [HC_W-1:0]  half_last;

    assign half_last = HC_W'(div) + HC_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            half_cnt <= '0;
            fall_cnt <= '0;
            sck      <= 1'b0;
            ws       <= 1'b0;
            rise_p   <= 1'b0;
        end else begin
            rise_p <= 1'b0;
            if (half_cnt == half_last) begin
                half_cnt <= '0;
                sck      <= ~sck;
                if (!sck) begin
                    rise_p <= 1'b1;
                end else if (fall_cnt == res - CNT_W'(1)) begin
                    fall_cnt <= '0;
                    ws       <= ~ws;
                end else begin
                    fall_cnt <= fall_cnt + CNT_W'(1);
                end
            end else begin
                half_cnt <= half_cnt + HC_W'(1);
            end
        end
    end
endmodule

// File: rtl/aud_rx_front.sv
module aud_rx_front
    import aud_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     master,
    input  logic     sck_in,
    input  logic     ws_in,
    input  logic     sd_in,
    input  logic     gen_rise,
    input  logic     gen_ws,
    output bit_evt_t evt
);
    logic [2:0] sck_sy;
    logic [1:0] ws_sy;
    logic [1:0] sd_sy;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sy <= '0;
            ws_sy  <= '0;
            sd_sy  <= '0;
        end else begin
            sck_sy <= {sck_sy[1:0], sck_in};
            ws_sy  <= {ws_sy[0], ws_in};
            sd_sy  <= {sd_sy[0], sd_in};
        end
    end

    always_comb begin
        if (master) begin
            evt.rise = gen_rise;
            evt.sd   = sd_in;
            evt.ws   = chan_e'(gen_ws);
        end else begin
            evt.rise = sck_sy[1] & ~sck_sy[2];
            evt.sd   = sd_sy[1];
            evt.ws   = chan_e'(ws_sy[1]);
        end
    end
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
    import aud_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              swap,
    input  logic [CNT_W-1:0]  res,
    input  bit_evt_t          evt,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] wr_addr
);
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] shreg_next;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-2:0] frame;
    chan_e             ws_prev;
    logic              synced;
    logic              take;
    logic              boundary;

    assign take       = bit_cnt < res;
    assign boundary   = evt.rise && (evt.ws != ws_prev);
    assign shreg_next = take ? {shreg[DATA_W-2:0], evt.sd} : shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
            frame   <= '0;
            ws_prev <= CH_LEFT;
            synced  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_data <= '0;
            wr_addr <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (!en) begin
                shreg   <= '0;
                bit_cnt <= '0;
                frame   <= '0;
                synced  <= 1'b0;
                ws_prev <= evt.ws;
            end else if (evt.rise) begin
                ws_prev <= evt.ws;
                if (boundary) begin
                    shreg   <= '0;
                    bit_cnt <= '0;
                    synced  <= 1'b1;
                    if (synced) begin
                        wr_stb  <= 1'b1;
                        wr_data <= shreg_next;
                        wr_addr <= {frame, logic'(ws_prev) ^ swap};
                        if (ws_prev == CH_RIGHT)
                            frame <= frame + (ADDR_W-1)'(1);
                    end
                end else begin
                    shreg <= shreg_next;
                    if (take)
                        bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/aud_i2s_rx.sv
module aud_i2s_rx
    import aud_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_master,
    input  logic              cfg_swap,
    input  logic [4:0]        cfg_res,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              sck_in,
    input  logic              ws_in,
    input  logic              sd_in,
    output logic              sck_out,
    output logic              ws_out,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [5:0]       res_full;
    logic [CNT_W-1:0] res_eff;
    logic             gen_rise;
    bit_evt_t         evt;

    assign res_full = clamp_res(cfg_res, DATA_W);
    assign res_eff  = CNT_W'(res_full);

    aud_rx_bitgen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_bitgen (
        .clk    (clk),
        .rst    (rst),
        .run    (cfg_en & cfg_master),
        .div    (cfg_div),
        .res    (res_eff),
        .sck    (sck_out),
        .ws     (ws_out),
        .rise_p (gen_rise)
    );

    aud_rx_front u_front (
        .clk      (clk),
        .rst      (rst),
        .master   (cfg_master),
        .sck_in   (sck_in),
        .ws_in    (ws_in),
        .sd_in    (sd_in),
        .gen_rise (gen_rise),
        .gen_ws   (ws_out),
        .evt      (evt)
    );

    aud_rx_deser #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_deser (
        .clk     (clk),
        .rst     (rst),
        .en      (cfg_en),
        .swap    (cfg_swap),
        .res     (res_eff),
        .evt     (evt),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .wr_addr (wr_addr)
    );
endmodule

// File: rtl/aud_i2s_rx_chk.sv
module aud_i2s_rx_chk
    import aud_rx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_en,
    input logic              cfg_master,
    input logic [4:0]        cfg_res,
    input logic              sck_out,
    input logic              ws_out,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_data
);
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    assert_zero_fill_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ((wr_data >> clamp_res(cfg_res, DATA_W)) == '0));

    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> !wr_stb);

    assert_ws_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_master && $past(cfg_en) && $past(cfg_master) && !$stable(ws_out))
            |-> $fell(sck_out));

    assert_gen_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !(cfg_en && cfg_master) |=> (!sck_out && !ws_out));
endmodule

bind aud_i2s_rx aud_i2s_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_en     (cfg_en),
    .cfg_master (cfg_master),
    .cfg_res    (cfg_res),
    .sck_out    (sck_out),
    .ws_out     (ws_out),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data)
);

// File: tb/aud_i2s_rx_bench.sv
module aud_i2s_rx_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_en, cfg_master, cfg_swap;
    logic [4:0]  cfg_res;
    logic [7:0]  cfg_div;
    logic        sck_in, ws_in, sd_in;
    logic        sck_out, ws_out, wr_stb;
    logic [31:0] wr_data;
    logic [7:0]  wr_addr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cap_n  = 0;
    logic [31:0] cap_d [0:127];
    logic [7:0]  cap_a [0:127];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (wr_stb && cap_n < 128) begin
            cap_d[cap_n] <= wr_data;
            cap_a[cap_n] <= wr_addr;
            cap_n        <= cap_n + 1;
        end
    end

    aud_i2s_rx u_aud_i2s_rx (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_master(cfg_master),
        .cfg_swap(cfg_swap), .cfg_res(cfg_res), .cfg_div(cfg_div),
        .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
        .sck_out(sck_out), .ws_out(ws_out), .wr_stb(wr_stb),
        .wr_data(wr_data), .wr_addr(wr_addr)
    );

    typedef struct packed {
        logic [4:0]  res;
        logic        swap;
        logic [5:0]  nbits;
        logic [31:0] left;
        logic [31:0] right;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{5'd16, 1'b0, 6'd16, 32'h0000A5C3, 32'h00001234},
        '{5'd24, 1'b1, 6'd24, 32'h00ABCDEF, 32'h00123456},
        '{5'd3,  1'b0, 6'd8,  32'h0000005A, 32'h000000C3},
        '{5'd0,  1'b1, 6'd12, 32'h00000ABC, 32'h00000123},
        '{5'd20, 1'b0, 6'd10, 32'h000002AB, 32'h00000155},
        '{5'd31, 1'b0, 6'd31, 32'h7FFF0001, 32'h40008000},
        '{5'd8,  1'b1, 6'd8,  32'h00000081, 32'h0000007E},
        '{5'd12, 1'b0, 6'd16, 32'h0000BEEF, 32'h0000CAFE}
    };

    function automatic int eff_res(input logic [4:0] r);
        return (r < 5'd8) ? 8 : int'(r);
    endfunction

    function automatic logic [31:0] expect_word(input logic [4:0] r, input int n, input logic [31:0] v);
        int e, k;
        logic [63:0] m;
        e = eff_res(r);
        k = (n < e) ? n : e;
        m = (64'd1 << k) - 64'd1;
        return 32'((64'(v) >> (n - k)) & m);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic w, input logic d);
        sck_in = 1'b0; ws_in = w; sd_in = d;
        repeat (4) @(negedge clk);
        sck_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic sword(input logic ch, input logic nxt, input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--)
            sbit((i == 0) ? nxt : ch, v[i]);
    endtask

    task automatic wait_rise(output int t);
        logic prev;
        prev = sck_out;
        for (int g = 0; g < 4000; g++) begin
            @(negedge clk);
            if (sck_out && !prev) break;
            prev = sck_out;
        end
        t = cyc;
    endtask

    task automatic run_master(input logic [7:0] dv, input logic [4:0] r, input logic sw, input logic sdv);
        int t0, t1, base, frame, rises;
        logic ch, w0;
        logic [31:0] ew;
        cfg_en = 1'b0; cfg_master = 1'b1; cfg_div = dv; cfg_res = r; cfg_swap = sw; sd_in = sdv;
        repeat (4) @(negedge clk);
        check("R3 sck idle while disabled", 64'(sck_out), 64'd0);
        base = cap_n;
        cfg_en = 1'b1;
        wait_rise(t0);
        wait_rise(t1);
        check("R3 bit clock period", 64'(t1 - t0), 64'(2 * (int'(dv) + 2)));
        w0 = ws_out;
        for (int g = 0; g < 80; g++) begin
            wait_rise(t0);
            if (ws_out != w0) break;
        end
        w0 = ws_out;
        rises = 0;
        for (int g = 0; g < 80; g++) begin
            wait_rise(t0);
            rises++;
            if (ws_out != w0) break;
        end
        check("R4 bit clocks per word select level", 64'(rises), 64'(eff_res(r)));
        for (int g = 0; g < 20000 && (cap_n - base) < 4; g++) @(negedge clk);
        check("R9 master writes present", 64'(cap_n - base >= 4), 64'd1);
        ew = sdv ? 32'((64'd1 << eff_res(r)) - 64'd1) : 32'd0;
        frame = 0;
        ch = 1'b1;
        for (int k = 0; k < 4; k++) begin
            check("R2 R5 master word data", 64'(cap_d[base + k]), 64'(ew));
            check("R6 master address", 64'(cap_a[base + k]), 64'({7'(frame), ch ^ sw}));
            if (ch) frame++;
            ch = ~ch;
        end
        cfg_en = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 generator stopped sck", 64'(sck_out), 64'd0);
        check("R10 generator stopped ws", 64'(ws_out), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int base;
        rst = 1'b1; cfg_en = 1'b0; cfg_master = 1'b0; cfg_swap = 1'b0;
        cfg_res = 5'd16; cfg_div = 8'd0; sck_in = 1'b0; ws_in = 1'b1; sd_in = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset wr_stb", 64'(wr_stb), 64'd0);
        check("R10 reset wr_data", 64'(wr_data), 64'd0);
        check("R3 reset sck_out", 64'(sck_out), 64'd0);
        check("R4 reset ws_out", 64'(ws_out), 64'd0);

        // Slave-mode vector walk (R11 path)
        for (int v = 0; v < NVEC; v++) begin
            cfg_en = 1'b0; cfg_res = VEC[v].res; cfg_swap = VEC[v].swap;
            sbit(1'b1, 1'b0);
            sbit(1'b1, 1'b0);
            base = cap_n;
            cfg_en = 1'b1;
            sword(1'b1, 1'b0, 32'h0000000F, 4);
            sword(1'b0, 1'b1, VEC[v].left, int'(VEC[v].nbits));
            sword(1'b1, 1'b0, VEC[v].right, int'(VEC[v].nbits));
            repeat (8) @(negedge clk);
            check("R9 R11 write count", 64'(cap_n - base), 64'd2);
            check("R1 R2 R8 left word", 64'(cap_d[base]),
                  64'(expect_word(VEC[v].res, int'(VEC[v].nbits), VEC[v].left)));
            check("R6 left address", 64'(cap_a[base]), 64'({7'd0, VEC[v].swap}));
            check("R1 R5 R8 right word", 64'(cap_d[base + 1]),
                  64'(expect_word(VEC[v].res, int'(VEC[v].nbits), VEC[v].right)));
            check("R6 right address", 64'(cap_a[base + 1]), 64'({7'd0, ~VEC[v].swap}));
        end

        // R10: a full frame while disabled writes nothing
        cfg_en = 1'b0;
        base = cap_n;
        sword(1'b0, 1'b1, 32'h00001111, 16);
        sword(1'b1, 1'b0, 32'h00002222, 16);
        repeat (8) @(negedge clk);
        check("R10 no writes while disabled", 64'(cap_n - base), 64'd0);
        check("R10 strobe low while disabled", 64'(wr_stb), 64'd0);

        // Master mode: divider, word-select spacing, data, addresses
        run_master(8'd0, 5'd8, 1'b0, 1'b1);
        run_master(8'd3, 5'd12, 1'b1, 1'b0);
        run_master(8'd1, 5'd2, 1'b0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule